// File: doc/BRIEF.md
# Packed Decimal Subtract-with-Borrow Unit

This block is a small coprocessor beside a CPU core. It subtracts two packed two-digit decimal bytes and an incoming borrow. The CPU fills three registers through a load port: a minuend/result byte (`acc`), a subtrahend byte (`sub`) and a 4-bit flag word. It then starts the operation with a single write on a simple write bus. That write must carry one fixed command value to one fixed address.

After a fixed latency, the unit writes the decimal-corrected difference back into `acc`. It reports a borrow flag and a zero flag, and it clears the overflow and negative flags. While the operation runs, `busy` is high. New start writes and register loads are refused during that time, so the operands cannot change under the computation. A one-cycle `done` pulse marks the cycle in which the result and the flags are new.

Operands with a digit above 9 give an undefined result. They are left out of all checking.

Top module: `bcd_sub_unit`

## Requirements
- R1: When `busy` is low, a cycle with `ld_we` high loads `ld_acc` into `acc_q`, `ld_sub` into `sub_q`, and `ld_flg` into the flags. The flag word is ordered bit 3 = VF, bit 2 = NF, bit 1 = CF, bit 0 = ZF, and CF is the incoming borrow.
- R2: A start happens only on a bus write (`bus_we` high) with `bus_wdata` = 0x80 and `bus_addr` = 0x03F07. A write with another value, or to another address, changes no output.
- R3: Each byte holds the tens digit in bits 7:4 and the units digit in bits 3:0. On completion, `acc_q` receives (acc − sub − CF) in decimal, taken modulo 100. For example, 0x00 − 0x01 − 0 gives 0x99.
- R4: On completion, CF is 1 when the true difference is below zero and 0 otherwise.
- R5: On completion, ZF is 1 when the new `acc_q` is 0x00 and 0 otherwise.
- R6: On completion, VF and NF are both 0, whatever was loaded into them.
- R7: `busy` is high for exactly 4 cycles, starting with the cycle after the start edge. `acc_q` and the flags change at the 4th clock edge after the start edge.
- R8: `done` is high for exactly one cycle: the cycle after the updating edge, with `busy` already low.
- R9: While `busy` is high, start writes and `ld_we` loads are ignored. `acc_q` stays unchanged until completion, and no second operation follows.
- R10: A synchronous active-high `rst` clears `acc_q`, `sub_q`, all four flags, `busy` and `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Register load strobe |
| ld_acc | input | 8 | Minuend to load |
| ld_sub | input | 8 | Subtrahend to load |
| ld_flg | input | 4 | Flag word to load {VF,NF,CF,ZF} |
| bus_we | input | 1 | Write-bus strobe |
| bus_addr | input | 18 | Write-bus address |
| bus_wdata | input | 8 | Write-bus data |
| acc_q | output | 8 | Minuend / result register |
| sub_q | output | 8 | Subtrahend register |
| vf | output | 1 | Overflow flag |
| nf | output | 1 | Negative flag |
| cf | output | 1 | Borrow flag |
| zf | output | 1 | Zero flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A start write is applied at one rising edge (E0). `busy` must then read high at each of the four following falling edges. The result, the flags and `done` are due one falling edge after E4, together with `busy` low. The bench drives every input at a falling edge and samples at a falling edge, so each result is read exactly in the cycle the requirement names. The sweep covers all 100 × 100 × 2 valid operand and borrow combinations. Expected values come from integer decimal arithmetic in the bench. Separate checks confirm that refused writes leave the registers intact until the next observable point.

// File: rtl/bcd_sub_pkg.sv
package bcd_sub_pkg;

  localparam int DIGIT_W = 4;
  localparam int BYTE_W  = 2 * DIGIT_W;
  localparam int FLG_W   = 4;

  // flag word positions
  localparam int FLG_VF = 3;
  localparam int FLG_NF = 2;
  localparam int FLG_CF = 1;
  localparam int FLG_ZF = 0;

  typedef struct packed {
    logic              borrow;
    logic [BYTE_W-1:0] value;
  } bcd_res_t;

  // one decimal digit minus another minus borrow, corrected
  function automatic logic [DIGIT_W:0] digit_sub(input logic [DIGIT_W-1:0] a,
                                                 input logic [DIGIT_W-1:0] b,
                                                 input logic               bin);
    logic [DIGIT_W:0] raw;
    raw = {1'b0, a} - {1'b0, b} - {{DIGIT_W{1'b0}}, bin};
    if (raw[DIGIT_W]) raw = raw - (DIGIT_W+1)'(6);
    // keep the borrow in the top bit, corrected digit below
    return {raw[DIGIT_W] | (({1'b0, a} < ({1'b0, b} + {{DIGIT_W{1'b0}}, bin}))),
            raw[DIGIT_W-1:0]};
  endfunction

  function automatic bcd_res_t bcd_sub_byte(input logic [BYTE_W-1:0] a,
                                            input logic [BYTE_W-1:0] b,
                                            input logic              bin);
    logic [DIGIT_W:0] lo, hi;
    bcd_res_t r;
    lo = digit_sub(a[DIGIT_W-1:0], b[DIGIT_W-1:0], bin);
    hi = digit_sub(a[BYTE_W-1:DIGIT_W], b[BYTE_W-1:DIGIT_W], lo[DIGIT_W]);
    r.borrow = hi[DIGIT_W];
    r.value  = {hi[DIGIT_W-1:0], lo[DIGIT_W-1:0]};
    return r;
  endfunction

endpackage

// File: rtl/bcd_sub_trig.sv
module bcd_sub_trig #(
  parameter int          ADDR_W   = 18,
  parameter int          DATA_W   = 8,
  parameter logic [17:0] TRIG_ADR = 18'h03F07,
  parameter logic [7:0]  TRIG_CMD = 8'h80
) (
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              busy,
  output logic              start
);

  logic hit_addr, hit_cmd;

  assign hit_addr = (bus_addr == ADDR_W'(TRIG_ADR));
  assign hit_cmd  = (bus_wdata == DATA_W'(TRIG_CMD));
  assign start    = bus_we && hit_addr && hit_cmd && !busy;

endmodule

// File: rtl/bcd_sub_seq.sv
module bcd_sub_seq #(
  parameter int LATENCY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic finish,
  output logic done
);

  localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LATENCY - 1);

  logic [CNT_W-1:0] cnt;

  assign finish = busy && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= finish;
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (finish) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (busy) begin
        cnt  <= cnt + 1'b1;
      end
    end
  end

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy); // R9
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_BUSY_RISES_ON_START: assert property (@(posedge clk) disable iff (rst)
    start |=> busy); // R7

endmodule

// File: rtl/bcd_sub_dp.sv
module bcd_sub_dp
  import bcd_sub_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we,
  input  logic [BYTE_W-1:0] ld_acc,
  input  logic [BYTE_W-1:0] ld_sub,
  input  logic [FLG_W-1:0]  ld_flg,
  input  logic              busy,
  input  logic              finish,
  output logic [BYTE_W-1:0] acc_q,
  output logic [BYTE_W-1:0] sub_q,
  output logic [FLG_W-1:0]  flg_q
);

  bcd_res_t res;
  logic     load_ok;

  assign res     = bcd_sub_byte(acc_q, sub_q, flg_q[FLG_CF]);
  assign load_ok = ld_we && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      sub_q <= '0;
      flg_q <= '0;
    end else if (finish) begin
      acc_q          <= res.value;
      flg_q[FLG_VF]  <= 1'b0;
      flg_q[FLG_NF]  <= 1'b0;
      flg_q[FLG_CF]  <= res.borrow;
      flg_q[FLG_ZF]  <= (res.value == '0);
    end else if (load_ok) begin
      acc_q <= ld_acc;
      sub_q <= ld_sub;
      flg_q <= ld_flg;
    end
  end

  AST_ACC_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && !finish) |=> $stable(acc_q) && $stable(sub_q)); // R9
  AST_VF_NF_CLEARED: assert property (@(posedge clk) disable iff (rst)
    finish |=> !flg_q[FLG_VF] && !flg_q[FLG_NF]); // R6
  AST_ZF_MATCHES: assert property (@(posedge clk) disable iff (rst)
    finish |=> (flg_q[FLG_ZF] == (acc_q == '0))); // R5

endmodule

// File: rtl/bcd_sub_unit.sv
module bcd_sub_unit #(
  parameter int ADDR_W  = 18,
  parameter int LATENCY = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we,
  input  logic [7:0]        ld_acc,
  input  logic [7:0]        ld_sub,
  input  logic [3:0]        ld_flg,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        acc_q,
  output logic [7:0]        sub_q,
  output logic              vf,
  output logic              nf,
  output logic              cf,
  output logic              zf,
  output logic              busy,
  output logic              done
);
  import bcd_sub_pkg::*;

  logic             start;
  logic             finish;
  logic [FLG_W-1:0] flg_q;

  bcd_sub_trig #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_trig (
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .busy(busy), .start(start)
  );

  bcd_sub_seq #(.LATENCY(LATENCY)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .busy(busy), .finish(finish), .done(done)
  );

  bcd_sub_dp u_dp (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_acc(ld_acc), .ld_sub(ld_sub),
    .ld_flg(ld_flg), .busy(busy), .finish(finish),
    .acc_q(acc_q), .sub_q(sub_q), .flg_q(flg_q)
  );

  assign vf = flg_q[FLG_VF];
  assign nf = flg_q[FLG_NF];
  assign cf = flg_q[FLG_CF];
  assign zf = flg_q[FLG_ZF];

  AST_DONE_WITH_FINISH: assert property (@(posedge clk) disable iff (rst)
    finish |=> done && !busy); // R7

endmodule

// File: tb/tb_bcd_sub_unit.sv
module tb_bcd_sub_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        ld_we;
  logic [7:0]  ld_acc, ld_sub;
  logic [3:0]  ld_flg;
  logic        bus_we;
  logic [17:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  acc_q, sub_q;
  logic        vf, nf, cf, zf, busy, done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bcd_sub_unit dut (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_acc(ld_acc), .ld_sub(ld_sub),
    .ld_flg(ld_flg), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .acc_q(acc_q), .sub_q(sub_q), .vf(vf), .nf(nf), .cf(cf), .zf(zf),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int to_bcd(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int from_bcd(input int b);
    return (b >> 4) * 10 + (b & 15);
  endfunction

  task automatic load(input int a, input int b, input bit c, input bit vfn);
    @(negedge clk);
    ld_we  = 1'b1;
    ld_acc = 8'(a);
    ld_sub = 8'(b);
    ld_flg = {vfn, vfn, c, vfn};
    @(negedge clk);
    ld_we  = 1'b0;
  endtask

  task automatic bus_write(input logic [17:0] adr, input logic [7:0] val);
    bus_we = 1'b1; bus_addr = adr; bus_wdata = val;
  endtask

  // full operation with timing checks; returns at negedge after done
  task automatic run_op(input int a, input int b, input bit c, input bit full);
    int diff;
    int exp_v;
    bit exp_c;
    bit ok;
    load(a, b, c, 1'b1);
    check(acc_q == 8'(a) && sub_q == 8'(b) && cf == c, "R1", acc_q, a);
    bus_write(18'h03F07, 8'h80);
    @(negedge clk);
    bus_we = 1'b0;
    if (full) check(busy == 1'b1, "R7", busy, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (full) check(busy == 1'b1 && !done && acc_q == 8'(a), "R7", busy, 1);
    end
    @(negedge clk);
    diff  = from_bcd(a) - from_bcd(b) - int'(c);
    exp_c = diff < 0;
    exp_v = to_bcd(exp_c ? diff + 100 : diff);
    ok = (acc_q == 8'(exp_v)) && (cf == exp_c) && (zf == (exp_v == 0)) &&
         !vf && !nf && done && !busy;
    check(ok, "R3 R4 R5 R6 R8", {acc_q, vf, nf, cf, zf, done, busy},
          {exp_v[7:0], 2'b00, exp_c, exp_v == 0, 2'b10});
    if (full) begin
      @(negedge clk);
      check(!done, "R8", done, 0);
    end
  endtask

  initial begin
    rst = 1'b1; ld_we = 1'b0; ld_acc = '0; ld_sub = '0; ld_flg = '0;
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    ld_we = 1'b1; ld_acc = 8'h55; ld_sub = 8'h22; ld_flg = 4'hF;
    @(negedge clk);
    ld_we = 1'b0;
    check(acc_q == 0 && sub_q == 0 && {vf, nf, cf, zf} == 0 && !busy && !done,
          "R10", {acc_q, sub_q}, 0);
    rst = 1'b0;

    // corner cases with full timing
    run_op('h00, 'h01, 1'b0, 1'b1);   // R3 wrap to 99
    check(acc_q == 8'h99 && cf, "R3", acc_q, 'h99);
    run_op('h50, 'h49, 1'b1, 1'b1);   // R5 zero with borrow in
    check(zf && acc_q == 0, "R5", zf, 1);
    run_op('h00, 'h99, 1'b1, 1'b1);   // R4 largest borrow -> 00
    check(cf && zf, "R4", {cf, zf}, 3);

    // R2 non-trigger writes
    load('h42, 'h17, 1'b0, 1'b1);
    @(negedge clk); bus_write(18'h03F07, 8'h81);
    @(negedge clk); bus_write(18'h03F06, 8'h80);
    @(negedge clk); bus_write(18'h13F07, 8'h80);
    @(negedge clk); bus_we = 1'b0; bus_write(18'h03F07, 8'h80); bus_we = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!busy && !done && acc_q == 8'h42 && vf && nf, "R2", {busy, acc_q}, 'h42);
    end

    // R9 start and load while busy
    load('h73, 'h25, 1'b0, 1'b0);
    bus_write(18'h03F07, 8'h80);
    @(negedge clk);
    ld_we = 1'b1; ld_acc = 8'h11; ld_sub = 8'h11; ld_flg = 4'h2;
    @(negedge clk);
    ld_we = 1'b0; bus_write(18'h03F07, 8'h80);
    @(negedge clk);
    bus_we = 1'b0;
    check(acc_q == 8'h73 && sub_q == 8'h25, "R9", acc_q, 'h73);
    @(negedge clk);
    @(negedge clk);
    check(done && acc_q == 8'h48 && !cf, "R9", acc_q, 'h48);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!busy && !done && acc_q == 8'h48, "R9", {busy, done}, 0);
    end

    // exhaustive sweep over valid operands and borrow
    for (int a = 0; a < 100; a++)
      for (int b = 0; b < 100; b++)
        for (int c = 0; c < 2; c++)
          run_op(to_bcd(a), to_bcd(b), c[0], 1'b0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

endmodule